// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Element

This block is one processing element of a large bit-serial array. A central sequencer broadcasts a stream of nanoinstructions to every element, and each element runs them against its own state. That state is a bit-addressable local memory, a small bank of one-bit flags and two operand latches. Two latch-loading instructions capture one memory bit each. A store instruction then combines the two latched bits with one selected flag through a three-input, two-output logic unit. Each output is set by its own 8-bit truth table carried in the instruction. One result bit goes back to memory and the other goes to a flag. Both writes are dropped while the context flag (flag 0) is clear.

Multi-bit arithmetic is built from repeated steps, one bit per step, with the carry held in a flag between steps. An N-bit add takes N load-load-store groups. Each element drives a carry bit that the array combines into a global OR, so the sequencer can learn whether any active element met a condition.

Nanoinstructions arrive on a valid/ready stream. A transfer happens on a rising clock edge where both valid and ready are high. Single result bits leave on a second valid/ready stream. The input stream is held off only while an output bit is waiting and the consumer is not ready.

Top module: `bsp_element`

## Requirements
- R1: After reset, every memory bit is 0 and flag 0 (context) is 1 while flags 1 to 7 are 0. `carry_out` and `out_valid` are 0, and `in_ready` is 1.
- R2: Opcode codes are NOP=0, LOADA=1, LOADB=2, STORE=3, SETCTX=4, READ=5; the codes 6 and 7 act as NOP. LOADA latches mem[`in_addr_a`] as operand A and LOADB latches mem[`in_addr_b`] as operand B. STORE forms the index {A, B, F}, with A as the MSB, where F is flag[`in_frd`] at the STORE.
- R3: With context 1, a STORE writes bit [index] of `in_tt_mem` to mem[`in_addr_a`] and bit [index] of `in_tt_flag` to flag[`in_fwr`]. The effect is visible to the next instruction.
- R4: With context 0, a STORE changes no memory bit and no flag.
- R5: SETCTX loads flag 0 from bit 0 of `in_tt_mem`, whatever the current context value.
- R6: `carry_out` updates only on a STORE. It becomes the flag-result bit ANDed with the context value in force at that STORE.
- R7: READ presents mem[`in_addr_a`] on `out_bit` with `out_valid` high from the next cycle. Both hold steady until a cycle where `out_ready` is high.
- R8: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. No instruction is lost or repeated under back-pressure.
- R9: A repeated LOADA/LOADB/STORE group adds two numbers in place. It uses carry flag 1, sum table 0x96 and carry table 0xE8, and gives (A+B) mod 2^N in A's bits, with the carry out left in flag 1, for N = 8 and N = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Nanoinstruction valid |
| in_ready | output | 1 | Element can accept a nanoinstruction |
| in_op | input | 3 | Opcode |
| in_addr_a | input | 12 | Operand A / destination bit address |
| in_addr_b | input | 12 | Operand B bit address |
| in_frd | input | 3 | Flag read select |
| in_fwr | input | 3 | Flag write select |
| in_tt_mem | input | 8 | Truth table for the memory result |
| in_tt_flag | input | 8 | Truth table for the flag result |
| out_valid | output | 1 | Read result valid |
| out_ready | input | 1 | Consumer accepts read result |
| out_bit | output | 1 | Read result bit |
| carry_out | output | 1 | Masked flag-result bit for the global OR |

## Verification
The assertions assume that the instruction fields are steady and meaningful only in cycles where `in_valid` is high. They also assume that the consumer does not rely on `out_bit` outside `out_valid`. The bench drives fields only together with valid and changes them at falling edges. It moves `out_ready` in mid-cycle on a fixed pattern, so back-pressure stalls happen while reads are still queued. Every operand bit enters memory through constant-table stores, so the element is only ever reached through its own instruction stream.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int MEM_BITS = 4096;
  localparam int NFLAG    = 8;
  localparam int OPW      = 3;
  localparam int TTW      = 8;
  localparam int NRES     = 2;

  typedef enum logic [OPW-1:0] {
    OP_NOP    = 3'd0,
    OP_LOADA  = 3'd1,
    OP_LOADB  = 3'd2,
    OP_STORE  = 3'd3,
    OP_SETCTX = 3'd4,
    OP_READ   = 3'd5
  } op_e;
endpackage

// File: rtl/bsp_decode.sv
module bsp_decode
  import bsp_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic [OPW-1:0] op,
  output logic           ld_a,
  output logic           ld_b,
  output logic           store,
  output logic           set_ctx,
  output logic           rd
);
  always_comb begin
    ld_a = 1'b0; ld_b = 1'b0; store = 1'b0; set_ctx = 1'b0; rd = 1'b0;
    if (fire) begin
      case (op)
        OP_LOADA:  ld_a    = 1'b1;
        OP_LOADB:  ld_b    = 1'b1;
        OP_STORE:  store   = 1'b1;
        OP_SETCTX: set_ctx = 1'b1;
        OP_READ:   rd      = 1'b1;
        default:   ;
      endcase
    end
  end

  // R2: at most one action per accepted instruction
  a_r2_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_a, ld_b, store, set_ctx, rd}));
endmodule

// File: rtl/bsp_alu.sv
module bsp_alu
  import bsp_pkg::*;
(
  input  logic                     bit_a,
  input  logic                     bit_b,
  input  logic                     bit_f,
  input  logic [NRES-1:0][TTW-1:0] tables,
  output logic [NRES-1:0]          result
);
  localparam int IW = $clog2(TTW);
  logic [IW-1:0] idx;
  assign idx = {bit_a, bit_b, bit_f};

  for (genvar k = 0; k < NRES; k++) begin : g_out
    assign result[k] = tables[k][idx];
  end
endmodule

// File: rtl/bsp_flags.sv
module bsp_flags #(
  parameter int N  = 8,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] rsel,
  output logic          rval,
  output logic          ctx,
  input  logic          wr_req,
  input  logic [SW-1:0] wsel,
  input  logic          wval,
  input  logic          set_ctx,
  input  logic          ctx_val
);
  logic [N-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= {{(N-1){1'b0}}, 1'b1};
    end else if (set_ctx) begin
      flags_q[0] <= ctx_val;
    end else if (wr_req && flags_q[0]) begin
      flags_q[wsel] <= wval;
    end
  end

  assign rval = flags_q[rsel];
  assign ctx  = flags_q[0];

  // R4: a masked write leaves every flag untouched
  a_r4_flags_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !ctx && !set_ctx) |=> $stable(flags_q));
  // R5: context load is unconditional
  a_r5_setctx: assert property (@(posedge clk) disable iff (!rst_n)
    set_ctx |=> (ctx == $past(ctx_val)));
endmodule

// File: rtl/bsp_element.sv
module bsp_element
  import bsp_pkg::*;
#(
  parameter int MEMSZ = MEM_BITS,
  parameter int NF    = NFLAG,
  localparam int AW   = $clog2(MEMSZ),
  localparam int FW   = $clog2(NF)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic [AW-1:0]  in_addr_a,
  input  logic [AW-1:0]  in_addr_b,
  input  logic [FW-1:0]  in_frd,
  input  logic [FW-1:0]  in_fwr,
  input  logic [TTW-1:0] in_tt_mem,
  input  logic [TTW-1:0] in_tt_flag,
  output logic           out_valid,
  input  logic           out_ready,
  output logic           out_bit,
  output logic           carry_out
);
  logic [MEMSZ-1:0] mem_q;
  logic             lat_a_q, lat_b_q;
  logic             fire, ld_a, ld_b, st, set_ctx, rd;
  logic             flag_rd, ctx;
  logic [NRES-1:0]  res;
  logic [NRES-1:0][TTW-1:0] tables;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign tables   = {in_tt_flag, in_tt_mem};

  bsp_decode u_dec (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(in_op),
    .ld_a(ld_a), .ld_b(ld_b), .store(st), .set_ctx(set_ctx), .rd(rd)
  );

  bsp_flags #(.N(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .rsel(in_frd), .rval(flag_rd), .ctx(ctx),
    .wr_req(st), .wsel(in_fwr), .wval(res[1]),
    .set_ctx(set_ctx), .ctx_val(in_tt_mem[0])
  );

  bsp_alu u_alu (
    .bit_a(lat_a_q), .bit_b(lat_b_q), .bit_f(flag_rd),
    .tables(tables), .result(res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q     <= '0;
      lat_a_q   <= 1'b0;
      lat_b_q   <= 1'b0;
      carry_out <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      if (ld_a) lat_a_q <= mem_q[in_addr_a];
      if (ld_b) lat_b_q <= mem_q[in_addr_b];
      if (st) begin
        carry_out <= ctx & res[1];
        if (ctx) mem_q[in_addr_a] <= res[0];
      end
      if (rd) begin
        out_valid <= 1'b1;
        out_bit   <= mem_q[in_addr_a];
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R4: masked store leaves memory unchanged
  a_r4_mem_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (st && !ctx) |=> (mem_q == $past(mem_q)));
  // R6: carry output moves only on a store
  a_r6_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !st |=> $stable(carry_out));
  // R7: result held under back-pressure
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));
  // R7: a result appears only after a read
  a_r7_out_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(rd));
  // R8: no acceptance while a result is stalled
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !fire);
endmodule

// File: tb/bsp_element_tb.sv
module bsp_element_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_op = '0;
  logic [11:0] in_addr_a = '0, in_addr_b = '0;
  logic [2:0] in_frd = '0, in_fwr = '0;
  logic [7:0] in_tt_mem = '0, in_tt_flag = '0;
  logic out_valid, out_ready = 1'b1, out_bit, carry_out;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  string tag_q[$];
  bit bp_en = 1'b0;

  always #4 clk = ~clk;

  bsp_element u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr_a(in_addr_a), .in_addr_b(in_addr_b),
    .in_frd(in_frd), .in_fwr(in_fwr), .in_tt_mem(in_tt_mem),
    .in_tt_flag(in_tt_flag), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .carry_out(carry_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // back-pressure pattern, changed mid-cycle away from both edges
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #2;
      cnt++;
      out_ready = bp_en ? ((cnt % 3) != 0) : 1'b1;
    end
  end

  // monitor: pop and compare on every output handshake
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 actual=unexpected_output expected=none");
        end else begin
          check(tag_q.pop_front(), out_bit, exp_q.pop_front());
        end
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [11:0] a, input logic [11:0] b,
                       input logic [2:0] frd, input logic [2:0] fwr,
                       input logic [7:0] ttm, input logic [7:0] ttf);
    @(negedge clk);
    in_op = op; in_addr_a = a; in_addr_b = b; in_frd = frd; in_fwr = fwr;
    in_tt_mem = ttm; in_tt_flag = ttf; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_op = 3'd0;
  endtask

  task automatic wr_bit(input logic [11:0] a, input logic v);
    issue(3'd3, a, 12'd0, 3'd0, 3'd7, v ? 8'hFF : 8'h00, 8'h00);
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic v, input string req);
    exp_q.push_back(v); tag_q.push_back(req);
    issue(3'd5, a, 12'd0, 3'd0, 3'd0, 8'h00, 8'h00);
  endtask

  task automatic set_ctx(input logic v);
    issue(3'd4, 12'd0, 12'd0, 3'd0, 3'd0, {7'd0, v}, 8'h00);
  endtask

  task automatic set_carry(input logic v);
    issue(3'd3, 12'd4095, 12'd0, 3'd0, 3'd1, 8'h00, v ? 8'hFF : 8'h00);
  endtask

  task automatic drain();
    idle();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // R9 bit-serial add of n bits; A at base_a, B at base_b
  task automatic run_add(input int n, input logic [11:0] base_a, input logic [11:0] base_b);
    for (int i = 0; i < n; i++) begin
      issue(3'd1, base_a + 12'(i), 12'd0, 3'd0, 3'd0, 8'h00, 8'h00);
      issue(3'd2, 12'd0, base_b + 12'(i), 3'd0, 3'd0, 8'h00, 8'h00);
      issue(3'd3, base_a + 12'(i), 12'd0, 3'd1, 3'd1, 8'h96, 8'hE8);
    end
  endtask

  task automatic add_test(input int n, input int a, input int b, input logic ctx_on);
    logic [11:0] ba, bb;
    int mask, sum;
    logic cy, expc;
    ba = 12'd200; bb = 12'd400;
    mask = (1 << n) - 1;
    for (int i = 0; i < n; i++) begin
      wr_bit(ba + 12'(i), a[i]);
      wr_bit(bb + 12'(i), b[i]);
    end
    set_carry(!ctx_on);
    if (!ctx_on) set_ctx(1'b0);
    run_add(n, ba, bb);
    idle();
    sum = ctx_on ? ((a + b) & mask) : a;
    cy  = ctx_on ? logic'(((a + b) >> n) & 1) : 1'b1;
    expc = ctx_on ? cy : 1'b0;
    check(ctx_on ? "R6 carry_out after add" : "R6 carry_out masked", carry_out, expc);
    if (!ctx_on) set_ctx(1'b1);
    // copy carry flag 1 into memory, then read it out
    issue(3'd3, 12'd4094, 12'd0, 3'd1, 3'd7, 8'hAA, 8'h00);
    rd_exp(12'd4094, cy, ctx_on ? "R9 carry flag" : "R4 carry flag unchanged");
    for (int i = 0; i < n; i++)
      rd_exp(ba + 12'(i), sum[i], ctx_on ? "R9 sum bit" : "R4 memory unchanged");
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check("R1 carry_out", carry_out, 1'b0);
    check("R1 out_valid", out_valid, 1'b0);
    check("R1 in_ready", in_ready, 1'b1);
    rd_exp(12'd100, 1'b0, "R1 memory zero");
    issue(3'd3, 12'd4094, 12'd0, 3'd5, 3'd7, 8'hAA, 8'h00);
    rd_exp(12'd4094, 1'b0, "R1 flag5 zero");
    issue(3'd3, 12'd4093, 12'd0, 3'd0, 3'd7, 8'hAA, 8'h00);
    rd_exp(12'd4093, 1'b1, "R1 context one");
    drain();

    // R2 operand order: mem10=1, mem11=0, F=ctx=1 -> index 5
    wr_bit(12'd10, 1'b1);
    wr_bit(12'd11, 1'b0);
    issue(3'd1, 12'd10, 12'd0, 3'd0, 3'd0, 8'h00, 8'h00);
    issue(3'd2, 12'd0, 12'd11, 3'd0, 3'd0, 8'h00, 8'h00);
    issue(3'd3, 12'd12, 12'd0, 3'd0, 3'd3, 8'h20, 8'h20);
    rd_exp(12'd12, 1'b1, "R2 index select");
    // R3 flag write: flag3 now 1, copy it to memory
    issue(3'd3, 12'd13, 12'd0, 3'd3, 3'd7, 8'hAA, 8'h00);
    rd_exp(12'd13, 1'b1, "R3 flag written");
    // codes 6,7 act as NOP
    issue(3'd6, 12'd12, 12'd0, 3'd0, 3'd0, 8'h00, 8'h00);
    issue(3'd7, 12'd12, 12'd0, 3'd0, 3'd0, 8'h00, 8'h00);
    rd_exp(12'd12, 1'b1, "R2 unused codes");
    drain();

    // R5: SETCTX works while context is 0; masked store between
    set_ctx(1'b0);
    wr_bit(12'd12, 1'b0);
    set_ctx(1'b1);
    rd_exp(12'd12, 1'b1, "R4 masked store");
    drain();

    add_test(8, 8'hFF, 8'h01, 1'b1);
    add_test(8, 8'h5A, 8'h3C, 1'b1);
    add_test(16, 16'hFFFF, 16'hFFFF, 1'b1);
    add_test(16, 16'h1234, 16'hEDCC, 1'b1);
    add_test(16, 16'hABCD, 16'h1111, 1'b1);
    add_test(8, 8'hC3, 8'h7E, 1'b0);
    add_test(16, 16'h8001, 16'h7FFF, 1'b0);

    // R7 R8 under back-pressure: a burst of reads
    bp_en = 1'b1;
    for (int i = 0; i < 16; i++) wr_bit(12'd600 + 12'(i), logic'(i % 3 == 0));
    for (int i = 0; i < 16; i++) rd_exp(12'd600 + 12'(i), logic'(i % 3 == 0), "R8 backpressure read");
    drain();
    add_test(8, 8'h81, 8'h7F, 1'b1);
    bp_en = 1'b0;

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 actual=%0d expected=0 pending", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule